// File: doc/BRIEF.md
# Recursive Sinusoidal Oscillator

This block produces a cosine sequence cos(w0·n) with a second-order recurrence. It is kicked by a single impulse sample and then runs on its own feedback. The frequency is set by a signed Q1.15 coefficient c = cos(w0), where w0 = 2π·f0/fs radians per sample and f0 must stay below fs/2.

Each accepted sample strobe advances the recurrence y[n] = 2c·y[n-1] − y[n-2] + x[n] − c·x[n-1] by one step. That step takes two multiplies and three additions. The block stores three past values (two outputs, one input) and the pair c and 2c.

Rounding error circulates through the feedback, so the amplitude can creep over a long run. A restart input clears the history and fires the impulse again, which puts a bound on that drift.

Top module: `tone_recur_gen`

## Requirements
- R1: After reset, sample_valid is 0, sample_out is 0, the coefficient is 0, the stored history is zero and the impulse is armed.
- R2: An accepted step computes acc = 2c·y1 + 2^15·x − 2^15·y2 − c·x1 at full width. It then rounds by adding 2^14 and shifting right arithmetically by 15. Here y1 and y2 are the previous outputs, x1 is the previous input and every quantity is a signed 16-bit integer. With c = 0 after reset, the output is 32767, 0, −32767, 0, 32767.
- R3: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R4: The input x is 32767 on the first accepted step after reset or restart and 0 on every later step.
- R5: A step is accepted when sample_strobe and out_en are both 1 and restart is 0. The new sample is on sample_out and sample_valid is 1 in the cycle after that edge, for exactly one cycle per accepted step.
- R6: In a cycle without an accepted step, the history does not advance, sample_out holds its value and sample_valid is 0 in the next cycle. This includes a strobe while out_en is 0.
- R7: coef_load latches coef_in as c (and 2c). A step accepted on the same edge still uses the previous coefficient.
- R8: restart clears the history and re-arms the impulse. It takes priority over a strobe on the same edge: no sample is produced and sample_out holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_in | input | 16 | Signed Q1.15 coefficient cos(w0) |
| coef_load | input | 1 | Latch coef_in as the new coefficient |
| restart | input | 1 | Clear history and re-arm the impulse |
| sample_strobe | input | 1 | Request one new sample |
| out_en | input | 1 | Output enable; a strobe is ignored while low |
| sample_out | output | 16 | Signed Q1.15 output sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
Saturation is the hardest case to reach. A pure sinusoid with |c| < 1 never leaves the 16-bit range.

The stimulus reaches it by running c = 0 for three samples, which leaves the history at −32767 and 0. It then reloads c = −32768, which drives the next result to 65534, so it must clip to 32767.

The same-edge collisions are driven on purpose: a coefficient load together with a strobe, and a restart together with a strobe. Long back-to-back and gapped runs compare every cycle against a behavioural model.

// File: rtl/osc_pkg.sv
package osc_pkg;
    localparam int DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_RESTART = 2'd2
    } step_act_e;
endpackage

// File: rtl/osc_coef_reg.sv
module osc_coef_reg #(
    parameter int DATA_W = 16,
    localparam int TWOC_W = DATA_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] coef_in,
    output logic signed [DATA_W-1:0] c_out,
    output logic signed [TWOC_W-1:0] twoc_out
);
    typedef struct packed {
        logic signed [DATA_W-1:0] c;
        logic signed [TWOC_W-1:0] twoc;
    } coef_t;

    coef_t cf_d, cf_q;

    always_comb begin
        cf_d = cf_q;
        if (load) begin
            cf_d.c    = coef_in;
            cf_d.twoc = TWOC_W'(coef_in) <<< 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q <= '0;
        end else begin
            cf_q <= cf_d;
        end
    end

    assign c_out    = cf_q.c;
    assign twoc_out = cf_q.twoc;

    // R7: a load latches the presented coefficient and its double
    a_r7_load_latches: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (c_out == $past(coef_in)) &&
                 (twoc_out == (TWOC_W'($past(coef_in)) <<< 1)));
endmodule

// File: rtl/osc_mac.sv
module osc_mac #(
    parameter int DATA_W = 16,
    localparam int FRAC   = DATA_W - 1,
    localparam int TWOC_W = DATA_W + 1,
    localparam int PROD_W = TWOC_W + DATA_W,
    localparam int ACC_W  = PROD_W + 3
) (
    input  logic signed [DATA_W-1:0] c,
    input  logic signed [TWOC_W-1:0] twoc,
    input  logic signed [DATA_W-1:0] y1,
    input  logic signed [DATA_W-1:0] y2,
    input  logic signed [DATA_W-1:0] x0,
    input  logic signed [DATA_W-1:0] x1,
    output logic signed [ACC_W-1:0]  acc
);
    logic signed [PROD_W-1:0] fb_prod;
    logic signed [PROD_W-1:0] ff_prod;
    logic signed [ACC_W-1:0]  fb_ext;
    logic signed [ACC_W-1:0]  ff_ext;
    logic signed [ACC_W-1:0]  y2_ext;
    logic signed [ACC_W-1:0]  x0_ext;

    always_comb begin
        fb_prod = twoc * y1;
        ff_prod = c * x1;
        fb_ext  = ACC_W'(fb_prod);
        ff_ext  = ACC_W'(ff_prod);
        y2_ext  = ACC_W'(y2) <<< FRAC;
        x0_ext  = ACC_W'(x0) <<< FRAC;
        acc     = fb_ext - y2_ext + x0_ext - ff_ext;
    end
endmodule

// File: rtl/osc_round_sat.sv
module osc_round_sat #(
    parameter int DATA_W        = 16,
    parameter int ACC_W         = 36,
    parameter bit ROUND_NEAREST = 1'b1,
    localparam int FRAC = DATA_W - 1
) (
    input  logic signed [ACC_W-1:0]  acc,
    output logic signed [DATA_W-1:0] result,
    output logic                     clipped
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    generate
        if (ROUND_NEAREST) begin : g_round
            assign biased = acc + HALF;
        end else begin : g_trunc
            assign biased = acc;
        end
    endgenerate

    always_comb begin
        scaled  = biased >>> FRAC;
        clipped = 1'b0;
        if (scaled > MAXV) begin
            result  = MAXV[DATA_W-1:0];
            clipped = 1'b1;
        end else if (scaled < MINV) begin
            result  = MINV[DATA_W-1:0];
            clipped = 1'b1;
        end else begin
            result = scaled[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/tone_recur_gen.sv
module tone_recur_gen #(
    parameter int DATA_W        = osc_pkg::DEF_DATA_W,
    parameter bit ROUND_NEAREST = 1'b1,
    localparam int TWOC_W = DATA_W + 1,
    localparam int ACC_W  = TWOC_W + DATA_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] coef_in,
    input  logic                     coef_load,
    input  logic                     restart,
    input  logic                     sample_strobe,
    input  logic                     out_en,
    output logic signed [DATA_W-1:0] sample_out,
    output logic                     sample_valid
);
    import osc_pkg::*;

    localparam logic signed [DATA_W-1:0] IMPULSE = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] out;
        logic                     valid;
        logic                     first;
    } osc_state_t;

    osc_state_t st_d, st_q;
    step_act_e  act;

    logic signed [DATA_W-1:0] c_cur;
    logic signed [TWOC_W-1:0] twoc_cur;
    logic signed [DATA_W-1:0] x_cur;
    logic signed [ACC_W-1:0]  acc;
    logic signed [DATA_W-1:0] y_new;
    logic                     y_clipped;

    osc_coef_reg #(.DATA_W(DATA_W)) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (coef_load),
        .coef_in  (coef_in),
        .c_out    (c_cur),
        .twoc_out (twoc_cur)
    );

    assign x_cur = st_q.first ? IMPULSE : '0;

    osc_mac #(.DATA_W(DATA_W)) u_mac (
        .c    (c_cur),
        .twoc (twoc_cur),
        .y1   (st_q.y1),
        .y2   (st_q.y2),
        .x0   (x_cur),
        .x1   (st_q.x1),
        .acc  (acc)
    );

    osc_round_sat #(
        .DATA_W        (DATA_W),
        .ACC_W         (ACC_W),
        .ROUND_NEAREST (ROUND_NEAREST)
    ) u_rs (
        .acc     (acc),
        .result  (y_new),
        .clipped (y_clipped)
    );

    always_comb begin
        if (restart) begin
            act = ACT_RESTART;
        end else if (sample_strobe && out_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        case (act)
            ACT_RESTART: begin
                st_d.y1    = '0;
                st_d.y2    = '0;
                st_d.x1    = '0;
                st_d.first = 1'b1;
            end
            ACT_STEP: begin
                st_d.y2    = st_q.y1;
                st_d.y1    = y_new;
                st_d.x1    = x_cur;
                st_d.out   = y_new;
                st_d.valid = 1'b1;
                st_d.first = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_out   = st_q.out;
    assign sample_valid = st_q.valid;

    // R5: an accepted step yields a valid pulse on the next cycle
    a_r5_step_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && out_en && !restart) |=> sample_valid);

    // R6: no accepted step leaves the output held and the valid low
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_strobe && out_en) |=> (!sample_valid && $stable(sample_out)));

    // R8: restart wipes history, wins over a strobe and holds the output
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sample_valid && $stable(sample_out) && st_q.first &&
                     st_q.y1 == '0 && st_q.y2 == '0 && st_q.x1 == '0));

    // R4: the first step after a restart emits the impulse response head
    a_r4_impulse_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && out_en && !restart && st_q.first) |=>
            (sample_out == IMPULSE && st_q.x1 == IMPULSE));

    // R3: a clipped result is exactly one of the two rails
    a_r3_clip_rails: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && y_clipped) |=>
            (sample_out == IMPULSE || sample_out == -IMPULSE - 1));
endmodule

// File: tb/tb_tone_recur_gen.sv
`timescale 1ns/1ps
module tb_tone_recur_gen;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] coef_in = '0;
    logic               coef_load = 1'b0;
    logic               restart = 1'b0;
    logic               sample_strobe = 1'b0;
    logic               out_en = 1'b0;
    logic signed [15:0] sample_out;
    logic               sample_valid;

    int checks = 0;
    int failures = 0;

    int m_c = 0, m_y1 = 0, m_y2 = 0, m_x1 = 0;
    bit m_first = 1'b1;
    int exp_out = 0;
    bit exp_valid = 1'b0;

    always #4 clk = ~clk;

    tone_recur_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .coef_in       (coef_in),
        .coef_load     (coef_load),
        .restart       (restart),
        .sample_strobe (sample_strobe),
        .out_en        (out_en),
        .sample_out    (sample_out),
        .sample_valid  (sample_valid)
    );

    function automatic int model_next(int c, int y1, int y2, int x, int x1);
        longint acc;
        longint r;
        acc = 64'sd2 * longint'(c) * longint'(y1) + longint'(x) * 64'sd32768
            - longint'(y2) * 64'sd32768 - longint'(c) * longint'(x1);
        r = (acc + 64'sd16384) >>> 15;
        if (r > 64'sd32767) r = 64'sd32767;
        if (r < -64'sd32768) r = -64'sd32768;
        return int'(r);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit stb, input bit en, input bit rs,
                       input bit ld, input int cf, input string tag);
        int x;
        sample_strobe = stb;
        out_en        = en;
        restart       = rs;
        coef_load     = ld;
        coef_in       = 16'(cf);
        if (rs) begin
            m_y1 = 0; m_y2 = 0; m_x1 = 0; m_first = 1'b1;
            exp_valid = 1'b0;
        end else if (stb && en) begin
            x = m_first ? 32767 : 0;
            exp_out = model_next(m_c, m_y1, m_y2, x, m_x1);
            m_y2 = m_y1;
            m_y1 = exp_out;
            m_x1 = x;
            m_first = 1'b0;
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
        if (ld) m_c = cf;
        @(posedge clk);
        @(negedge clk);
        sample_strobe = 1'b0;
        out_en        = 1'b0;
        restart       = 1'b0;
        coef_load     = 1'b0;
        chk({tag, " valid"}, int'(sample_valid), int'(exp_valid));
        chk({tag, " out"}, int'(sample_out), exp_out);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin : main
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(sample_valid), 0);
        chk("R1 out", int'(sample_out), 0);

        // R1 / R2 / R4: default coefficient 0 gives period-4 pattern
        cyc(1, 1, 0, 0, 0, "R4 first");
        chk("R4 impulse", int'(sample_out), 32767);
        cyc(1, 1, 0, 0, 0, "R2 c0 s1");
        chk("R1 c0 s1", int'(sample_out), 0);
        cyc(1, 1, 0, 0, 0, "R2 c0 s2");
        chk("R2 c0 s2", int'(sample_out), -32767);
        cyc(1, 1, 0, 0, 0, "R2 c0 s3");
        cyc(1, 1, 0, 0, 0, "R2 c0 s4");
        chk("R2 c0 s4", int'(sample_out), 32767);

        // R6: strobe without enable, and idle cycles
        held = int'(sample_out);
        cyc(1, 0, 0, 0, 0, "R6 no enable");
        chk("R6 held", int'(sample_out), held);
        cyc(0, 1, 0, 0, 0, "R6 enable only");
        cyc(0, 0, 0, 0, 0, "R6 idle");
        cyc(1, 1, 0, 0, 0, "R6 resume");

        // R8: restart with strobe on the same edge
        held = int'(sample_out);
        cyc(1, 1, 1, 0, 0, "R8 restart+strobe");
        chk("R8 held", int'(sample_out), held);
        cyc(1, 1, 0, 0, 0, "R8 impulse again");
        chk("R8 impulse", int'(sample_out), 32767);

        // R7: load with strobe uses the old coefficient (0 -> expect 0)
        cyc(1, 1, 0, 1, 16384, "R7 load+strobe");
        chk("R7 old coef", int'(sample_out), 0);
        cyc(1, 1, 0, 0, 0, "R7 new coef");
        cyc(0, 0, 1, 0, 0, "R7 restart");
        cyc(1, 1, 0, 0, 0, "R7 c half s0");
        cyc(1, 1, 0, 0, 0, "R7 c half s1");
        chk("R7 c half s1", int'(sample_out), 16384);
        cyc(1, 1, 0, 0, 0, "R2 c half s2");
        chk("R2 c half s2", int'(sample_out), -16383);

        // R3: force a result beyond the positive rail
        cyc(0, 0, 1, 1, 0, "R3 setup");
        cyc(1, 1, 0, 0, 0, "R3 s0");
        cyc(1, 1, 0, 0, 0, "R3 s1");
        cyc(1, 1, 0, 0, 0, "R3 s2");
        cyc(0, 0, 0, 1, -32768, "R3 load neg one");
        cyc(1, 1, 0, 0, 0, "R3 clip");
        chk("R3 clip", int'(sample_out), 32767);
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, "R3 after clip");

        // R2 / R5: long back-to-back run
        cyc(0, 0, 1, 1, 30000, "R2 long setup");
        for (int i = 0; i < 900; i++) cyc(1, 1, 0, 0, 0, "R5 back to back");

        // R2 / R6: gapped run with a negative coefficient near the top
        cyc(0, 0, 1, 1, -20000, "R2 neg setup");
        for (int i = 0; i < 400; i++) begin
            cyc(1, 1, 0, 0, 0, "R2 gapped step");
            cyc((i % 3) == 0, 0, 0, 0, 0, "R6 gap");
        end

        // R2: slow tone near DC, long enough to see rounding drift
        cyc(0, 0, 1, 1, 32767, "R2 dc setup");
        for (int i = 0; i < 2000; i++) cyc(1, 1, 0, 0, 0, "R2 near dc");

        summary();
    end
endmodule